// File: doc/BRIEF.md
# DMA Burst Splitting Engine

This block sits between a DMA request source and a system bus master. It takes one transfer request (a byte start address, a beat count and a read/write flag) and cuts it into a series of bus bursts. Each burst leaves on a valid/ready channel as a start address and a length in beats. Each beat is 4 bytes wide, so after a burst the address moves on by 4 times its length. The block does not move data. It only plans the bursts and counts how many are still open on the bus. It takes one completion pulse for each burst the bus finishes.

The split follows a mode word that is sampled when a request is accepted. The mode word has an enable for each of the lengths 16, 8 and 4, an "any length" flag and an "align to address" flag. In fixed-length mode (any-length flag clear), the block uses only the enabled lengths, largest first, and drops to single beats when none of them fits. In any-length mode, it sends bursts of the largest enabled length and then one shorter burst for the remainder. In align mode, the block first sends short bursts until the address sits on a boundary of the largest enabled length. Two limit fields, one for reads and one for writes, cap the number of open bursts at the limit plus one. When every burst of a request has been sent and completed, `done` pulses for one cycle.

The control is a four-state machine:
- `ST_IDLE` waits for a request.
- `ST_ISSUE` sends bursts.
- `ST_DRAIN` waits until the open-burst count reaches zero.
- `ST_FINISH` raises `done` for one cycle.

The transitions are:
- IDLE→ISSUE: a request with a nonzero count is accepted.
- IDLE→FINISH: a request with a zero count is accepted.
- ISSUE→DRAIN: the last burst is handed over.
- DRAIN→FINISH: no bursts are open.
- FINISH→IDLE: always, after one cycle.

Top module: `burst_split_top`

## Requirements
- R1: After reset, `bst_valid` and `done` are 0 and `req_ready` is 1.
- R2: Fixed-length mode, selected when the any-length flag is 0. Each burst takes the first enabled length, checked in the order 16, 8, 4, that is no larger than the remaining beats. If none fits, the burst is 1 beat long. With all three lengths enabled, 42 beats give 16,16,8,1,1.
- R3: Any-length mode, selected when the any-length flag is 1. Each burst is the smaller of the remaining beats and the largest enabled length. With only 16 enabled, 42 beats give 16,16,10. With only 8 enabled, 13 beats give 8,5.
- R4: No burst is longer than the largest enabled length. If no length is enabled, every burst is 1 beat, in either mode.
- R5: Align mode. Let M be the largest enabled length and k the beat index (address divided by 4). While k is not a multiple of M, the allowed size is limited to the smaller of the remaining beats and M − (k mod M). The length rule of R2 or R3 then applies to that limit. With all lengths enabled, any-length mode, 42 beats at 0x3A4 give 7,16,16,3.
- R6: The first burst starts at the request address. Each later burst starts 4×(previous length) bytes further on. `bst_write` equals the request's write flag.
- R7: Bursts sent minus completions counted never exceeds limit+1. The limit is `cfg_wr_limit` for writes and `cfg_rd_limit` for reads. When no completions arrive, exactly limit+1 bursts go out and then `bst_valid` stays low.
- R8: While `bst_valid` is 1 and `bst_ready` is 0, `bst_valid`, `bst_addr` and `bst_len` hold their values at the next cycle.
- R9: A request is accepted only in `ST_IDLE`, so `req_ready` is 0 from acceptance until after `done`. The mode word and the limits are sampled at acceptance, and later changes do not affect the request in progress.
- R10: `done` is high for exactly one cycle. It rises only after every burst of the request has been sent and has received its completion.
- R11: A request with a beat count of 0 sends no burst, and `done` pulses one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len4_en | input | 1 | Enable 4-beat bursts |
| cfg_len8_en | input | 1 | Enable 8-beat bursts |
| cfg_len16_en | input | 1 | Enable 16-beat bursts |
| cfg_any_len | input | 1 | Any-length mode (1) or fixed-length mode (0) |
| cfg_align | input | 1 | Align mode |
| cfg_rd_limit | input | LIM_W | Read open-burst limit minus one |
| cfg_wr_limit | input | LIM_W | Write open-burst limit minus one |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | Request direction, 1 = write |
| req_addr | input | ADDR_W | Request start byte address |
| req_beats | input | CNT_W | Request beat count |
| bst_valid | output | 1 | Burst offered |
| bst_ready | input | 1 | Bus takes the burst |
| bst_write | output | 1 | Burst direction |
| bst_addr | output | ADDR_W | Burst start byte address |
| bst_len | output | LEN_W | Burst length in beats |
| cmpl_valid | input | 1 | One burst completed |
| done | output | 1 | Request fully completed (one-cycle pulse) |

## Verification
A wrong remaining-count or address register shows up on the very next handed-over burst, as a wrong `bst_len` or `bst_addr`. The scoreboard catches it on that handshake. A wrong open-burst count shows up in one of two ways, depending on its direction:
- If it is too high, `bst_valid` stalls for good and the request never reaches `done`.
- If it is too low, a burst beyond limit+1 goes out, which is seen at that handshake.

A state machine that leaves `ST_DRAIN` early makes `done` rise while the bench still holds completions. This is detected in the cycle of the pulse.

// File: rtl/burst_split_pkg.sv
package burst_split_pkg;

    localparam int MAX_BURST = 16;
    localparam int LEN_W     = $clog2(MAX_BURST) + 1;

    typedef struct packed {
        logic en4;
        logic en8;
        logic en16;
        logic any_len;
        logic align;
    } split_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } split_state_t;

endpackage

// File: rtl/burst_len_pick.sv
module burst_len_pick
    import burst_split_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 12,
    parameter int BEAT_SH = 2
) (
    input  split_mode_t        mode,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   remaining,
    output logic [LEN_W-1:0]   len,
    output logic [LEN_W-1:0]   max_len
);

    localparam int OFS_W = LEN_W - 1;

    logic [OFS_W-1:0] beat_low;
    logic [OFS_W-1:0] ofs_mask;
    logic [OFS_W-1:0] offset;
    logic [LEN_W-1:0] gap;
    logic [CNT_W-1:0] cap;

    // largest enabled length, priority 16, 8, 4, else single beat
    always_comb begin
        if (mode.en16)      max_len = LEN_W'(16);
        else if (mode.en8)  max_len = LEN_W'(8);
        else if (mode.en4)  max_len = LEN_W'(4);
        else                max_len = LEN_W'(1);
    end

    // distance in beats to the next boundary of the largest length
    always_comb begin
        beat_low = addr[BEAT_SH +: OFS_W];
        ofs_mask = max_len[OFS_W-1:0] - 1'b1;
        offset   = beat_low & ofs_mask;
        gap      = max_len - {1'b0, offset};
        if (mode.align && (offset != '0) && (remaining > CNT_W'(gap)))
            cap = CNT_W'(gap);
        else
            cap = remaining;
    end

    // length choice within the cap
    always_comb begin
        if (mode.any_len) begin
            if (cap >= CNT_W'(max_len)) len = max_len;
            else                        len = cap[LEN_W-1:0];
        end else begin
            if (mode.en16 && cap >= CNT_W'(16))     len = LEN_W'(16);
            else if (mode.en8 && cap >= CNT_W'(8))  len = LEN_W'(8);
            else if (mode.en4 && cap >= CNT_W'(4))  len = LEN_W'(4);
            else                                    len = LEN_W'(1);
        end
    end

endmodule

// File: rtl/burst_credit.sv
module burst_credit #(
    parameter int LIM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             retire_req,
    input  logic [LIM_W-1:0] limit,
    output logic             room,
    output logic             empty
);

    localparam int CW = LIM_W + 1;

    logic [CW-1:0] open_cnt;
    logic          retire;

    // a completion with nothing open is dropped
    assign retire = retire_req && (open_cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_cnt <= '0;
        end else begin
            unique case ({issue, retire})
                2'b10:   open_cnt <= open_cnt + 1'b1;
                2'b01:   open_cnt <= open_cnt - 1'b1;
                default: open_cnt <= open_cnt;
            endcase
        end
    end

    always_comb begin
        room  = (open_cnt <= {1'b0, limit});
        empty = (open_cnt == '0);
    end

    assert_open_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        open_cnt <= ({1'b0, limit} + 1'b1));

    assert_issue_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !retire) |=> (open_cnt == $past(open_cnt) + 1'b1));

endmodule

// File: rtl/burst_split_top.sv
module burst_split_top
    import burst_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 12,
    parameter int LIM_W      = 3,
    parameter int BEAT_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_len4_en,
    input  logic                        cfg_len8_en,
    input  logic                        cfg_len16_en,
    input  logic                        cfg_any_len,
    input  logic                        cfg_align,
    input  logic [LIM_W-1:0]            cfg_rd_limit,
    input  logic [LIM_W-1:0]            cfg_wr_limit,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [CNT_W-1:0]            req_beats,
    output logic                        bst_valid,
    input  logic                        bst_ready,
    output logic                        bst_write,
    output logic [ADDR_W-1:0]           bst_addr,
    output logic [burst_split_pkg::LEN_W-1:0] bst_len,
    input  logic                        cmpl_valid,
    output logic                        done
);

    localparam int BEAT_SH = $clog2(BEAT_BYTES);

    split_state_t     state_q, state_d;
    split_mode_t      mode_q;
    logic [LIM_W-1:0] lim_q;
    logic             wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0] rem_q;

    logic             accept;
    logic             fire;
    logic             last_burst;
    logic [LEN_W-1:0] pick_len;
    logic [LEN_W-1:0] pick_max;
    logic             credit_room;
    logic             credit_empty;

    burst_len_pick #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .BEAT_SH (BEAT_SH)
    ) u_pick (
        .mode      (mode_q),
        .addr      (addr_q),
        .remaining (rem_q),
        .len       (pick_len),
        .max_len   (pick_max)
    );

    burst_credit #(
        .LIM_W (LIM_W)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (fire),
        .retire_req (cmpl_valid),
        .limit      (lim_q),
        .room       (credit_room),
        .empty      (credit_empty)
    );

    assign accept     = req_valid && req_ready;
    assign fire       = bst_valid && bst_ready;
    assign last_burst = (rem_q == CNT_W'(pick_len));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = (req_beats == '0) ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  if (fire && last_burst) state_d = ST_DRAIN;
            ST_DRAIN:  if (credit_empty) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request context and walking address/count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            lim_q  <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
        end else if (accept) begin
            mode_q <= '{en4: cfg_len4_en, en8: cfg_len8_en, en16: cfg_len16_en,
                        any_len: cfg_any_len, align: cfg_align};
            lim_q  <= req_write ? cfg_wr_limit : cfg_rd_limit;
            wr_q   <= req_write;
            addr_q <= req_addr;
            rem_q  <= req_beats;
        end else if (fire) begin
            addr_q <= addr_q + (ADDR_W'(pick_len) << BEAT_SH);
            rem_q  <= rem_q - CNT_W'(pick_len);
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        bst_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_ISSUE:  bst_valid = credit_room;
            ST_DRAIN:  ;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
        bst_write = wr_q;
        bst_addr  = addr_q;
        bst_len   = pick_len;
    end

    assert_len_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (bst_len != '0) && (bst_len <= pick_max) && (CNT_W'(bst_len) <= rem_q));

    assert_fixed_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !mode_q.any_len) |->
            (bst_len == LEN_W'(1) || bst_len == LEN_W'(4) ||
             bst_len == LEN_W'(8) || bst_len == LEN_W'(16)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_addr) && $stable(bst_len)));

    assert_idle_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bst_valid && !done);

    assert_done_drained_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> credit_empty && !req_ready);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last_burst) |=> bst_addr != $past(bst_addr));

endmodule

// File: tb/burst_split_top_bench.sv
`timescale 1ns/1ps
module burst_split_top_bench;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 12;
    localparam int LIM_W  = 3;
    localparam int LEN_W  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_len4_en = 1'b0, cfg_len8_en = 1'b0, cfg_len16_en = 1'b0;
    logic cfg_any_len = 1'b0, cfg_align = 1'b0;
    logic [LIM_W-1:0] cfg_rd_limit = '0, cfg_wr_limit = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0]  req_beats = '0;
    logic bst_valid, bst_write;
    logic bst_ready = 1'b0;
    logic [ADDR_W-1:0] bst_addr;
    logic [LEN_W-1:0]  bst_len;
    logic cmpl_valid = 1'b0;
    logic done;

    always #4 clk = ~clk;

    burst_split_top u_burst_split_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_len4_en(cfg_len4_en), .cfg_len8_en(cfg_len8_en), .cfg_len16_en(cfg_len16_en),
        .cfg_any_len(cfg_any_len), .cfg_align(cfg_align),
        .cfg_rd_limit(cfg_rd_limit), .cfg_wr_limit(cfg_wr_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_beats(req_beats),
        .bst_valid(bst_valid), .bst_ready(bst_ready), .bst_write(bst_write),
        .bst_addr(bst_addr), .bst_len(bst_len),
        .cmpl_valid(cmpl_valid), .done(done)
    );

    typedef struct { logic [31:0] a; int l; logic w; } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_bad = 0;
    int fires = 0, cmpls = 0;
    int cur_lim = 0;
    bit rdy_always = 1'b1, cmpl_hold = 1'b0, mon_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit prev_stall = 1'b0;
    logic [ADDR_W-1:0] prev_addr;
    logic [LEN_W-1:0]  prev_len;

    task automatic check(bit ok, string req, string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic void push(logic [31:0] a, int l, logic w);
        exp_t e;
        e.a = a; e.l = l; e.w = w;
        exp_q.push_back(e);
    endfunction

    // expected split computed from the requirements
    function automatic void plan(logic [31:0] a0, int beats, logic w,
                                 bit e4, bit e8, bit e16, bit anyl, bit al);
        int mx, rem, off, cap, l;
        logic [31:0] a;
        mx  = e16 ? 16 : (e8 ? 8 : (e4 ? 4 : 1));
        rem = beats;
        a   = a0;
        while (rem > 0) begin
            off = int'(a >> 2) % mx;
            cap = rem;
            if (al && off != 0 && rem > mx - off) cap = mx - off;
            if (anyl) l = (cap >= mx) ? mx : cap;
            else if (e16 && cap >= 16) l = 16;
            else if (e8 && cap >= 8)   l = 8;
            else if (e4 && cap >= 4)   l = 4;
            else                       l = 1;
            push(a, l, w);
            a   = a + 32'(4 * l);
            rem = rem - l;
        end
    endfunction

    // monitor / responder: decide inputs for the next edge, then score it
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            int occ;
            exp_t e;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bst_ready = rdy_always || lfsr[0];
            occ = fires - cmpls;
            cmpl_valid = !cmpl_hold && (occ > 0) && lfsr[3];
            if (prev_stall)
                check(bst_valid && bst_addr == prev_addr && bst_len == prev_len, "R8",
                      $sformatf("held burst changed: v=%0b a=%h l=%0d exp a=%h l=%0d",
                                bst_valid, bst_addr, bst_len, prev_addr, prev_len));
            if (bst_valid && bst_ready) begin
                check(occ <= cur_lim, "R7",
                      $sformatf("open bursts %0d exceed limit+1=%0d", occ + 1, cur_lim + 1));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", $sformatf("unexpected burst a=%h l=%0d exp none", bst_addr, bst_len));
                end else begin
                    e = exp_q.pop_front();
                    check(bst_addr == e.a && int'(bst_len) == e.l && bst_write == e.w, "R6",
                          $sformatf("burst a=%h l=%0d w=%0b exp a=%h l=%0d w=%0b",
                                    bst_addr, bst_len, bst_write, e.a, e.l, e.w));
                end
                fires++;
            end
            if (cmpl_valid) cmpls++;
            prev_stall = bst_valid && !bst_ready;
            prev_addr  = bst_addr;
            prev_len   = bst_len;
        end
    end

    task automatic set_mode(bit e4, bit e8, bit e16, bit anyl, bit al);
        cfg_len4_en = e4; cfg_len8_en = e8; cfg_len16_en = e16;
        cfg_any_len = anyl; cfg_align = al;
    endtask

    task automatic send_req(logic [31:0] a, int beats, logic w);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_lim   = w ? int'(cfg_wr_limit) : int'(cfg_rd_limit);
        req_addr  = a;
        req_beats = CNT_W'(beats);
        req_write = w;
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        @(negedge clk);
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done === 1'b1, "R10", $sformatf("done=%0b exp 1", done));
        check(exp_q.size() == 0, req, $sformatf("%0d expected bursts left, exp 0", exp_q.size()));
        check(fires == cmpls, "R10", $sformatf("done with %0d open, exp 0", fires - cmpls));
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, "R10",
              $sformatf("after done: done=%0b ready=%0b exp 0/1", done, req_ready));
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired (R10 never reached)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(bst_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1",
              $sformatf("reset v=%0b d=%0b r=%0b exp 0/0/1", bst_valid, done, req_ready));
        mon_on = 1'b1;
        cfg_rd_limit = 3'd3; cfg_wr_limit = 3'd2;

        // R2: fixed lengths, 42 beats
        set_mode(1, 1, 1, 0, 0);
        push(32'h1000, 16, 0); push(32'h1040, 16, 0); push(32'h1080, 8, 0);
        push(32'h10A0, 1, 0);  push(32'h10A4, 1, 0);
        send_req(32'h1000, 42, 0);
        wait_done("R2");

        // R3: any length, 16 only
        set_mode(0, 0, 1, 1, 0);
        push(32'h2000, 16, 1); push(32'h2040, 16, 1); push(32'h2080, 10, 1);
        send_req(32'h2000, 42, 1);
        wait_done("R3");

        // R3/R4: any length, 8 only
        set_mode(0, 1, 0, 1, 0);
        push(32'h3000, 8, 0); push(32'h3020, 5, 0);
        send_req(32'h3000, 13, 0);
        wait_done("R4");

        // R5: align, any length, all enabled at 0x3A4
        set_mode(1, 1, 1, 1, 1);
        push(32'h3A4, 7, 0); push(32'h3C0, 16, 0); push(32'h400, 16, 0); push(32'h440, 3, 0);
        send_req(32'h3A4, 42, 0);
        wait_done("R5");

        // R5: align, fixed lengths
        set_mode(1, 1, 1, 0, 1);
        plan(32'h3A4, 42, 1, 1, 1, 1, 0, 1);
        send_req(32'h3A4, 42, 1);
        wait_done("R5");

        // R4: only 4 enabled, then none enabled
        set_mode(1, 0, 0, 0, 0);
        push(32'h500, 4, 0); push(32'h510, 4, 0); push(32'h520, 1, 0); push(32'h524, 1, 0);
        send_req(32'h500, 10, 0);
        wait_done("R4");
        set_mode(0, 0, 0, 1, 1);
        push(32'h604, 1, 0); push(32'h608, 1, 0); push(32'h60C, 1, 0);
        send_req(32'h604, 3, 0);
        wait_done("R4");

        // R11: zero count
        f0 = fires;
        send_req(32'h700, 0, 0);
        @(negedge clk);
        check(done == 1'b1, "R11", $sformatf("done=%0b one cycle after zero request, exp 1", done));
        check(fires == f0, "R11", $sformatf("%0d bursts for zero request, exp 0", fires - f0));
        @(negedge clk);

        // R7: read limit 1 -> 2 open, write limit 3 -> 4 open
        cfg_rd_limit = 3'd1; cfg_wr_limit = 3'd3;
        set_mode(1, 1, 1, 0, 0);
        cmpl_hold = 1'b1;
        f0 = fires;
        plan(32'h8000, 64, 0, 1, 1, 1, 0, 0);
        send_req(32'h8000, 64, 0);
        repeat (30) @(negedge clk);
        check(fires - f0 == 2 && bst_valid == 1'b0, "R7",
              $sformatf("read: %0d sent v=%0b while held, exp 2 v=0", fires - f0, bst_valid));
        check(req_ready == 1'b0, "R9", $sformatf("req_ready=%0b while busy, exp 0", req_ready));
        cmpl_hold = 1'b0;
        wait_done("R7");
        cmpl_hold = 1'b1;
        f0 = fires;
        plan(32'h9000, 96, 1, 1, 1, 1, 0, 0);
        send_req(32'h9000, 96, 1);
        repeat (30) @(negedge clk);
        check(fires - f0 == 4, "R7", $sformatf("write: %0d sent while held, exp 4", fires - f0));
        cmpl_hold = 1'b0;
        wait_done("R7");

        // R9: mode changed after acceptance is ignored
        cfg_rd_limit = 3'd2;
        set_mode(0, 0, 1, 1, 0);
        plan(32'hA000, 42, 0, 0, 0, 1, 1, 0);
        send_req(32'hA000, 42, 0);
        set_mode(1, 0, 0, 0, 1);
        cfg_rd_limit = 3'd0;
        wait_done("R9");

        // R6/R8: varied patterns with random ready and completions
        rdy_always = 1'b0;
        for (int i = 0; i < 24; i++) begin
            bit e4, e8, e16, anyl, al, w;
            int beats;
            logic [31:0] a;
            e4 = lfsr[1]; e8 = lfsr[4]; e16 = lfsr[7]; anyl = lfsr[9]; al = lfsr[11];
            w = lfsr[2];
            beats = 1 + (int'(lfsr[14:8]) % 70);
            a = {20'h0, lfsr[11:2], 2'b00};
            cfg_rd_limit = LIM_W'(i % 8); cfg_wr_limit = LIM_W'((i + 3) % 8);
            set_mode(e4, e8, e16, anyl, al);
            plan(a, beats, w, e4, e8, e16, anyl, al);
            send_req(a, beats, w);
            wait_done("R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule